// File: doc/BRIEF.md
# Registered Address Buffer with Parity Check

This block sits on the command/address path of a memory module. A 28-bit word is registered on the rising clock edge, and each registered bit is driven onto two identical output copies, giving 56 output bits. Two active-low chip selects decide whether the registered word may change on a given edge. A gate-enable input can switch off that decision so that the word updates on every edge.

A parity checker runs beside the data path. It covers the low 22 data bits and a parity bit from the controller. It registers them, counts the ones, and shows the result on an active-low error flag one clock later. A synchronous active-low reset clears the data outputs and drives the flag to its inactive high level.

The block has no flow control. A word is accepted on every clock edge, and there is no back-pressure. Whether that word reaches the outputs depends only on the chip selects and the gate enable.

Top module: `addr_regbuf`

## Requirements
- R1: On a rising edge with `rst_n` low, every bit of `q_out` becomes 0 and `err_n` becomes 1. Both hold these values until the first edge after `rst_n` returns high. The parity history is cleared, so the first flag after reset is 1.
- R2: When an edge loads the word, `q_out` shows the `d_in` value sampled at that edge, right after the edge.
- R3: Copy 0 (`q_out[27:0]`) and copy 1 (`q_out[55:28]`) are always equal.
- R4: With `gate_en` high, an edge loads the word when at least one bit of `cs_n` is 0.
- R5: With `gate_en` high and `cs_n` equal to 2'b11, an edge leaves `q_out` unchanged, whatever `d_in` holds.
- R6: With `gate_en` low, every edge loads the word, including when `cs_n` is 2'b11.
- R7: The check uses even parity over `d_in[21:0]` and `par_in`. If the count of ones in those 23 bits at edge k is odd, `err_n` is 0 after edge k+1. This includes a single flipped bit anywhere in `d_in[21:0]`, including bit 21, and a flipped `par_in` alone.
- R8: If that count is even, `err_n` is 1 after edge k+1. This includes two flipped bits.
- R9: `d_in[27:22]` have no effect on `err_n`.
- R10: Parity is sampled on every edge, whatever the values of `cs_n` and `gate_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| d_in | input | 28 | Command/address word |
| par_in | input | 1 | Parity bit from the controller, even parity over `d_in[21:0]` |
| cs_n | input | 2 | Chip selects, active low |
| gate_en | input | 1 | High: chip selects gate updates. Low: the word updates every edge |
| q_out | output | 56 | Two copies of the registered word; copy c at bits [28c+27:28c] |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The data outputs settle one edge after a stimulus, and the parity flag settles two edges after it: one edge to capture the inputs and one to register the result. The bench drives each vector at a falling edge and samples one falling edge later. At that point it compares `q_out` with its model for the current vector and compares `err_n` with the parity expected for the previous vector. Single-bit and double-bit faults, the excluded upper bits, and the reset behaviour each get their own vectors so that every check can be traced to one requirement.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;
  localparam int unsigned WORD_W   = 28;
  localparam int unsigned CHECK_W  = 22;
  localparam int unsigned N_COPIES = 2;
  localparam int unsigned N_CS     = 2;
endpackage

// File: rtl/regbuf_gate.sv
module regbuf_gate #(
  parameter int unsigned N_CS = 2
) (
  input  logic [N_CS-1:0] cs_n,
  input  logic            gate_en,
  output logic            load
);
  logic any_sel;

  always_comb begin
    any_sel = 1'b0;
    for (int i = 0; i < int'(N_CS); i++) begin
      any_sel = any_sel | ~cs_n[i];
    end
    load = any_sel | ~gate_en;
  end
endmodule

// File: rtl/regbuf_capture.sv
module regbuf_capture #(
  parameter int unsigned WORD_W = 28,
  parameter int unsigned N_CS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  input  logic [N_CS-1:0]   cs_n,
  input  logic              gate_en,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

  AST_HOLD_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (&cs_n)) |=> $stable(q)) else $error("word changed while deselected"); // R5

  AST_LOAD_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !(&cs_n)) |=> (q == $past(d))) else $error("word not loaded under select"); // R4

  AST_LOAD_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en) |=> (q == $past(d))) else $error("word not loaded with gating off"); // R6
endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity #(
  parameter int unsigned CHECK_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CHECK_W-1:0] d_sub,
  input  logic               par,
  output logic               err_n
);
  localparam int unsigned CAP_W = CHECK_W + 1;

  logic [CAP_W-1:0] cap_q;
  logic             odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q <= {par, d_sub};
    end
  end

  always_comb odd = ^cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_n <= 1'b1;
    end else begin
      err_n <= ~odd;
    end
  end

  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_q <= 2'd0;
    end else if (settle_q != 2'd2) begin
      settle_q <= settle_q + 2'd1;
    end
  end

  AST_FLAG_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2) |-> (err_n == ~(^$past({par, d_sub}, 2)))) else $error("parity flag mismatch"); // R7

  AST_FLAG_HIGH_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd0) |-> err_n) else $error("flag low right after reset"); // R1
endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout #(
  parameter int unsigned WORD_W   = 28,
  parameter int unsigned N_COPIES = 2
) (
  input  logic [WORD_W-1:0]          word,
  output logic [N_COPIES*WORD_W-1:0] copies
);
  for (genvar c = 0; c < int'(N_COPIES); c++) begin : g_copy
    assign copies[c*WORD_W +: WORD_W] = word;
  end
endmodule

// File: rtl/addr_regbuf.sv
module addr_regbuf
  import regbuf_pkg::*;
#(
  parameter int unsigned P_WORD_W   = WORD_W,
  parameter int unsigned P_CHECK_W  = CHECK_W,
  parameter int unsigned P_N_COPIES = N_COPIES,
  parameter int unsigned P_N_CS     = N_CS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [P_WORD_W-1:0]               d_in,
  input  logic                              par_in,
  input  logic [P_N_CS-1:0]                 cs_n,
  input  logic                              gate_en,
  output logic [P_N_COPIES*P_WORD_W-1:0]    q_out,
  output logic                              err_n
);
  logic                load;
  logic [P_WORD_W-1:0] word_q;

  regbuf_gate #(.N_CS(P_N_CS)) u_gate (
    .cs_n    (cs_n),
    .gate_en (gate_en),
    .load    (load)
  );

  regbuf_capture #(.WORD_W(P_WORD_W), .N_CS(P_N_CS)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .d       (d_in),
    .cs_n    (cs_n),
    .gate_en (gate_en),
    .q       (word_q)
  );

  regbuf_parity #(.CHECK_W(P_CHECK_W)) u_parity (
    .clk   (clk),
    .rst_n (rst_n),
    .d_sub (d_in[P_CHECK_W-1:0]),
    .par   (par_in),
    .err_n (err_n)
  );

  regbuf_fanout #(.WORD_W(P_WORD_W), .N_COPIES(P_N_COPIES)) u_fanout (
    .word   (word_q),
    .copies (q_out)
  );

  logic rst_seen_q;
  always_ff @(posedge clk) begin
    if (rst_seen_q) begin
      AST_RESET_CLEARS: assert (q_out == '0 && err_n == 1'b1) else $error("reset state wrong"); // R1
    end
    rst_seen_q <= !rst_n;
  end
endmodule

// File: tb/addr_regbuf_tb.sv
module addr_regbuf_tb;
  localparam int W  = 28;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  d_in;
  logic          par_in;
  logic [1:0]    cs_n;
  logic          gate_en;
  logic [2*W-1:0] q_out;
  logic          err_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [W-1:0] m_word;
  logic         m_err_prev;

  always #10 clk = ~clk;

  addr_regbuf u_dut (
    .clk(clk), .rst_n(rst_n), .d_in(d_in), .par_in(par_in),
    .cs_n(cs_n), .gate_en(gate_en), .q_out(q_out), .err_n(err_n)
  );

  // {gate_en, cs_n[1:0], par_in, d_in[27:0]}
  localparam logic [31:0] VEC [NV] = '{
    32'hC000_0001, 32'hA123_4567, 32'hE0FF_FFFF, 32'hF555_5555,
    32'h6ABC_DEF0, 32'h7000_0003, 32'hC3F0_0000, 32'hE800_0000,
    32'h1FFF_FFFF, 32'h9002_0001, 32'hB3C0_0000, 32'hD0C0_FFEE
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic p, input logic [1:0] cs, input logic ge,
                       input string ptag);
    string qtag;
    logic  exp_err;
    @(negedge clk);
    d_in = d; par_in = p; cs_n = cs; gate_en = ge;
    @(posedge clk);
    @(negedge clk);
    if (ge && cs == 2'b11) qtag = "R5";
    else if (!ge) begin qtag = "R6"; m_word = d; end
    else begin qtag = "R4"; m_word = d; end
    check({qtag, "/R2 word"}, 64'(q_out[W-1:0]), 64'(m_word));
    check("R3 copies", 64'(q_out[2*W-1:W]), 64'(q_out[W-1:0]));
    check(m_err_prev ? "R8 flag" : "R7 flag", 64'(err_n), 64'(m_err_prev));
    exp_err = ~(^{p, d[21:0]});
    if (ptag != "") begin
      @(negedge clk);
      check(ptag, 64'(err_n), 64'(exp_err));
      if (ge && cs == 2'b11) ;
    end
    m_err_prev = exp_err;
    if (ptag != "") begin
      // the extra cycle above held the same vector, so the word model is unchanged
      m_err_prev = exp_err;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; d_in = '0; par_in = 1'b0; cs_n = 2'b11; gate_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", 64'(q_out), 64'd0);
    check("R1 reset flag", 64'(err_n), 64'd1);
    rst_n = 1'b1;
    m_word = '0; m_err_prev = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27:0], VEC[i][28], VEC[i][30:29], VEC[i][31], "");
    end

    // gating corners
    apply(28'h0AAAAAA, 1'b0, 2'b10, 1'b1, "");
    apply(28'h0555555, 1'b0, 2'b11, 1'b1, "");  // R5 hold
    apply(28'h0123456, 1'b1, 2'b01, 1'b1, "");  // R4 single select
    apply(28'h0FEDCBA, 1'b0, 2'b11, 1'b0, "");  // R6 gating off

    // parity faults, each observed one edge later (R7, R8, R9, R10)
    apply(28'h0000000, 1'b0, 2'b00, 1'b1, "R8 clean word");
    apply(28'h0000020, 1'b0, 2'b00, 1'b1, "R7 single bit 5");
    apply(28'h0000220, 1'b0, 2'b00, 1'b1, "R8 double bit 5,9");
    apply(28'h0000000, 1'b1, 2'b00, 1'b1, "R7 parity bit alone");
    apply(28'h0200000, 1'b0, 2'b00, 1'b1, "R7 single bit 21");
    apply(28'h8000000 >> 1, 1'b0, 2'b00, 1'b1, "R9 upper bit 26");
    apply(28'hFC00000, 1'b0, 2'b00, 1'b1, "R9 upper bits 22..27 with bit 22");
    apply(28'h0000040, 1'b0, 2'b11, 1'b1, "R10 fault while deselected");
    apply(28'h0000300, 1'b0, 2'b11, 1'b1, "R10 double fault while deselected");

    // reset with an error pending
    apply(28'h0000001, 1'b0, 2'b00, 1'b1, "");
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset clears word", 64'(q_out), 64'd0);
    check("R1 reset forces flag high", 64'(err_n), 64'd1);
    rst_n = 1'b1; d_in = '0; par_in = 1'b1; cs_n = 2'b11; gate_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 first flag after reset", 64'(err_n), 64'd1);
    check("R1 word held after reset", 64'(q_out), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule